// File: doc/BRIEF.md
# Configurable Digital Input Glitch Filter

This block cleans up one asynchronous digital line, such as an external trigger, before a timer uses it. The line first passes through a two-stage synchronizer on the kernel clock. It is then sampled at a rate chosen by a 4-bit filter code. The filtered output takes a new level only after a run of consecutive samples shows that level. The length of the run also comes from the code.

The code does not give the run length directly. It indexes a fixed table. Each entry pairs a sample rate with a run length. The rate is either every kernel clock, or a base sampling tick divided by 1, 2, 4, 8, 16 or 32. The base tick arrives as a one-cycle enable input. A free-running tick counter produces the divided rates.

When the code changes, the run counter and the divider restart. The output keeps its level until a fresh run completes under the new setting.

Top module: `din_glitch_filter`

## Requirements
- R1: While rst_ni is low, dout_o is 0, the run counter is 0 and the tick divider is 0.
- R2: din_i passes through two kernel-clock flops before it is sampled. With code 0001, a steady change of din_i present before edge 1 appears on dout_o after edge 4.
- R3: Code 0000 disables filtering. On every cycle with base_tick_i high, dout_o takes the synchronized input level.
- R4: Codes 0001, 0010 and 0011 sample on every kernel cycle. They need runs of 2, 4 and 8 samples, which gives input-to-output latencies of 4, 6 and 10 kernel cycles.
- R5: The divided rates and their run lengths are fixed by the code:
  - 0100 and 0101: divide by 2, runs of 6 and 8.
  - 0110 and 0111: divide by 4, runs of 6 and 8.
  - 1000 and 1001: divide by 8, runs of 6 and 8.
  - 1010, 1011 and 1100: divide by 16, runs of 5, 6 and 8.
  - 1101, 1110 and 1111: divide by 32, runs of 5, 6 and 8.
- R6: dout_o changes only on a sample cycle. It changes only when that sample completes N consecutive samples that differ from dout_o.
- R7: A sample equal to dout_o clears the run counter. Glitches shorter than N samples therefore never add up, however many of them arrive.
- R8: A change of code clears the run counter and the divider in the same edge. dout_o holds its level through that edge.
- R9: The divider is a 5-bit counter. It starts at 0, advances only on base_tick_i, and samples on a tick whose low log2(D) bits are all ones. The first divided sample after a restart is therefore the D-th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 1 | Asynchronous input line |
| base_tick_i | input | 1 | One-cycle enable pulse of the base sampling clock |
| code_i | input | 4 | Filter code selecting sample rate and run length |
| dout_o | output | 1 | Filtered level |

## Verification
On every cycle, the assertions check four things:
- The output moves only on a sample cycle that ends a full run.
- A sample equal to the output empties the counter.
- The counter stays below the run length.
- A code change clears the counter and the divider while the output holds.

Only the bench scenarios can show that the decode table is right. They also measure the exact kernel-cycle latencies, confirm that repeated short glitches are rejected, and confirm the tick phase at which divided sampling starts. For these, the bench runs a behavioural model through every code and compares against the design on every clock.

// File: rtl/gf_pkg.sv
package gf_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned CNT_W  = 4;
  localparam int unsigned LG_W   = 3;
  localparam int unsigned DIV_W  = 5;

  typedef struct packed {
    logic             kern;
    logic [LG_W-1:0]  lg_div;
    logic [CNT_W-1:0] need;
  } flt_cfg_t;

  function automatic flt_cfg_t decode_code(input logic [CODE_W-1:0] c);
    flt_cfg_t r;
    r.kern   = 1'b0;
    r.lg_div = '0;
    r.need   = CNT_W'(1);
    unique case (c)
      4'h0: r.need = CNT_W'(1);
      4'h1: begin r.kern = 1'b1; r.need = CNT_W'(2); end
      4'h2: begin r.kern = 1'b1; r.need = CNT_W'(4); end
      4'h3: begin r.kern = 1'b1; r.need = CNT_W'(8); end
      4'h4: begin r.lg_div = LG_W'(1); r.need = CNT_W'(6); end
      4'h5: begin r.lg_div = LG_W'(1); r.need = CNT_W'(8); end
      4'h6: begin r.lg_div = LG_W'(2); r.need = CNT_W'(6); end
      4'h7: begin r.lg_div = LG_W'(2); r.need = CNT_W'(8); end
      4'h8: begin r.lg_div = LG_W'(3); r.need = CNT_W'(6); end
      4'h9: begin r.lg_div = LG_W'(3); r.need = CNT_W'(8); end
      4'hA: begin r.lg_div = LG_W'(4); r.need = CNT_W'(5); end
      4'hB: begin r.lg_div = LG_W'(4); r.need = CNT_W'(6); end
      4'hC: begin r.lg_div = LG_W'(4); r.need = CNT_W'(8); end
      4'hD: begin r.lg_div = LG_W'(5); r.need = CNT_W'(5); end
      4'hE: begin r.lg_div = LG_W'(5); r.need = CNT_W'(6); end
      default: begin r.lg_div = LG_W'(5); r.need = CNT_W'(8); end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gf_rate_div.sv
module gf_rate_div
  import gf_pkg::*;
#(
  parameter int unsigned DW = DIV_W,
  parameter int unsigned LW = LG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic          kern_i,
  input  logic [LW-1:0] lg_div_i,
  output logic          smp_en_o,
  output logic [DW-1:0] div_o
);
  logic [DW-1:0] div_q;
  logic [DW-1:0] mask;
  logic          phase_hit;

  // low lg_div bits select the divide phase
  assign mask      = ~({DW{1'b1}} << lg_div_i);
  assign phase_hit = &(div_q | ~mask);
  assign smp_en_o  = !clr_i && (kern_i || (tick_i && phase_hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (tick_i) div_q <= div_q + DW'(1);
  end

  assign div_o = div_q;
endmodule

// File: rtl/gf_event_cnt.sv
module gf_event_cnt
  import gf_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          smp_en_i,
  input  logic          smp_i,
  input  logic [CW-1:0] need_i,
  output logic          lvl_o,
  output logic [CW-1:0] cnt_o
);
  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic          run_done;

  assign run_done = (cnt_q == need_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (smp_en_i) begin
      if (smp_i == lvl_q) begin
        cnt_q <= '0;
      end else if (run_done) begin
        lvl_q <= smp_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign lvl_o = lvl_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/din_glitch_filter.sv
module din_glitch_filter
  import gf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              din_i,
  input  logic              base_tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              dout_o
);
  logic [CODE_W-1:0] code_q;
  logic              code_chg;
  flt_cfg_t          cfg;
  logic              din_s;
  logic              smp_en;
  logic [DIV_W-1:0]  div_val;
  logic [CNT_W-1:0]  run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_i;
  end

  assign code_chg = (code_i != code_q);
  assign cfg      = decode_code(code_i);

  gf_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (din_i),
    .q_o    (din_s)
  );

  gf_rate_div #(.DW(DIV_W), .LW(LG_W)) i_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (code_chg),
    .tick_i   (base_tick_i),
    .kern_i   (cfg.kern),
    .lg_div_i (cfg.lg_div),
    .smp_en_o (smp_en),
    .div_o    (div_val)
  );

  gf_event_cnt #(.CW(CNT_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (code_chg),
    .smp_en_i (smp_en),
    .smp_i    (din_s),
    .need_i   (cfg.need),
    .lvl_o    (dout_o),
    .cnt_o    (run_cnt)
  );
endmodule

// File: rtl/gf_filter_chk.sv
module gf_filter_chk
  import gf_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             base_tick_i,
  input logic             dout_o,
  input logic             code_chg,
  input logic             smp_en,
  input logic             din_s,
  input logic [CNT_W-1:0] run_cnt,
  input logic [CNT_W-1:0] need,
  input logic [DIV_W-1:0] div_val
);
  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (dout_o == 1'b0 && run_cnt == '0 && div_val == '0)
        else $error("R1 reset state");
    end
  end

  // R6
  a_r6_change_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_o != $past(dout_o)) |->
      ($past(smp_en) && ($past(run_cnt) == $past(need) - CNT_W'(1))));

  // R6
  a_r6_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_chg |-> (run_cnt < need));

  // R7
  a_r7_match_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_en && din_s == dout_o) |=> (run_cnt == '0));

  // R8
  a_r8_code_change_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_chg |=> (run_cnt == '0 && div_val == '0 && $stable(dout_o)));

  // R9
  a_r9_div_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!base_tick_i && !code_chg) |=> $stable(div_val));
endmodule

bind din_glitch_filter gf_filter_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .base_tick_i (base_tick_i),
  .dout_o      (dout_o),
  .code_chg    (code_chg),
  .smp_en      (smp_en),
  .din_s       (din_s),
  .run_cnt     (run_cnt),
  .need        (cfg.need),
  .div_val     (div_val)
);

// File: tb/test_din_glitch_filter.sv
module test_din_glitch_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       din = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] code = 4'h0;
  logic       dout;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  string phase = "R1";
  int tick_per = 3;
  bit tick_rand = 1'b0;

  always #4 clk = ~clk;

  din_glitch_filter i_din_glitch_filter (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .base_tick_i(tick),
    .code_i(code), .dout_o(dout)
  );

  // reference tables
  function automatic int rate_div(input int c);
    if (c == 0) return 1;
    if (c <= 3) return 0;  // every kernel cycle
    if (c <= 5) return 2;
    if (c <= 7) return 4;
    if (c <= 9) return 8;
    if (c <= 12) return 16;
    return 32;
  endfunction

  function automatic int run_len(input int c);
    int t[16] = '{1, 2, 4, 8, 6, 8, 6, 8, 6, 8, 5, 6, 8, 5, 6, 8};
    return t[c];
  endfunction

  // behavioural reference
  bit m_sync[$] = '{1'b0, 1'b0};
  int m_div = 0, m_cnt = 0, m_prev_code = 0;
  bit m_out = 1'b0;

  always @(posedge clk) begin
    bit s;
    bit take;
    int d;
    if (!rst_n) begin
      m_sync = '{1'b0, 1'b0};
      m_div = 0; m_cnt = 0; m_prev_code = 0; m_out = 1'b0;
    end else begin
      s = m_sync.pop_front();
      m_sync.push_back(din);
      if (int'(code) != m_prev_code) begin
        m_div = 0; m_cnt = 0;
      end else begin
        d = rate_div(int'(code));
        take = (d == 0) ? 1'b1 : (tick && (m_div % d) == d - 1);
        if (tick) m_div = (m_div + 1) % 32;
        if (take) begin
          if (s == m_out) m_cnt = 0;
          else begin
            m_cnt++;
            if (m_cnt >= run_len(int'(code))) begin m_out = s; m_cnt = 0; end
          end
        end
      end
      m_prev_code = int'(code);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      tests++;
      if (dout !== m_out) begin
        fails++;
        $display("FAIL %s per-cycle dout actual=%0b expected=%0b code=%0d t=%0t",
                 phase, dout, m_out, code, $time);
      end
    end
  end

  // base tick generator
  int tk = 0;
  always @(negedge clk) begin
    if (tick_rand) tick <= ($urandom_range(0, 2) == 0);
    else begin
      tk = (tk + 1) % tick_per;
      tick <= (tk == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latency(input int c, input string req);
    int edges;
    code = 4'(c); din = 1'b0;
    cyc(20);
    din = 1'b1;
    edges = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); edges++;
      if (dout) break;
    end
    chk(req, edges, 2 + run_len(c));
    din = 1'b0; cyc(20);
  endtask

  initial begin
    bit seen;
    // R1
    cyc(3);
    chk("R1 dout in reset", int'(dout), 0);
    din = 1'b1; cyc(2);
    chk("R1 dout held in reset", int'(dout), 0);
    din = 1'b0;
    rst_n = 1'b1;
    cmp_on = 1'b1;
    cyc(5);

    // R2 R4 latency
    phase = "R4";
    latency(1, "R2 R4 code1 latency");
    latency(2, "R4 code2 latency");
    latency(3, "R4 code3 latency");

    // R7 glitch rejection, code 2 (N=4)
    phase = "R7";
    code = 4'h2; din = 1'b0; cyc(20);
    seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      din = 1'b1; for (int j = 0; j < 3; j++) begin @(negedge clk); seen |= dout; end
      din = 1'b0; begin @(negedge clk); seen |= dout; end
    end
    cyc(10); seen |= dout;
    chk("R7 repeated short glitches ignored", int'(seen), 0);

    // R8 code change mid-run
    phase = "R8";
    code = 4'h3; din = 1'b0; cyc(20);
    din = 1'b1; cyc(6);
    code = 4'h2;
    cyc(4);
    chk("R8 dout held after code change", int'(dout), 0);
    cyc(1);
    chk("R8 new run completes", int'(dout), 1);
    din = 1'b0; cyc(20);

    // R3 unfiltered with random ticks
    phase = "R3";
    code = 4'h0; tick_rand = 1'b1;
    for (int k = 0; k < 400; k++) begin din = 1'($urandom_range(0, 1)); cyc(1); end
    tick_rand = 1'b0;
    din = 1'b1; cyc(12);
    chk("R3 follows input", int'(dout), 1);
    din = 1'b0; cyc(12);

    // R9 first divided sample on D-th tick, code 4 (div2,N=6): 12 ticks
    phase = "R9";
    tick_per = 1;
    code = 4'h4; din = 1'b1; cyc(12);
    chk("R9 divided run not yet complete", int'(dout), 0);
    cyc(3);
    chk("R9 divided run complete", int'(dout), 1);
    din = 1'b0; cyc(20);
    tick_per = 3;

    // R5 R6 every divided code with slow random input
    phase = "R5";
    for (int c = 4; c < 16; c++) begin
      code = 4'(c);
      for (int k = 0; k < 6; k++) begin
        din = ~din;
        cyc($urandom_range(20, 350));
        if (($urandom_range(0, 3)) == 0) begin din = ~din; cyc(2); din = ~din; end
      end
    end
    din = 1'b1; code = 4'h1; cyc(10);
    chk("R6 final level", int'(dout), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired in %s", phase);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule